// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block maps each bus address to one of a small set of software-programmed address windows. Every window holds a base, a size mask in 64 KB units, a target identifier, an attribute byte and an enable bit. The decode is purely combinational: the upper sixteen address bits are compared with each window's base, with the bits covered by the size mask left out of the compare. The block reports whether any window matched, which window won, and that window's target and attribute.

A window's size field is a thermometer code. The ones start at bit 0 and are followed only by zeros. A field with k ones spans 2^k units of 64 KB, so 0x0000 is the smallest window (64 KB), 0x00FF spans 16 MB and 0x0FFF spans 256 MB. A field that is not of this form is reported as invalid, and that window is kept out of the decode. When windows overlap, the lowest-numbered window wins. Software programs one whole window per write cycle.

Top module: `addr_window_decoder`

## Requirements
- R1: While reset is held, and after it is released with no write yet made, every window is disabled: `miss` is 1, `hit` is 0 and `cfg_invalid` is all zeros.
- R2: A write with `cfg_we` high stores `cfg_en`, `cfg_base`, `cfg_size`, `cfg_target` and `cfg_attr` into window `cfg_idx` at the rising clock edge. The decode uses the new contents from that edge on, and not before it.
- R3: Window i matches when it is enabled, its size field is valid, and `(addr[31:16] ^ base) & ~size` is zero. Address bits [15:0] never affect the decode.
- R4: A size field of 0x0000 matches exactly one 64 KB block, the one whose `addr[31:16]` equals the base.
- R5: A valid size field with k ones matches the aligned block of 2^k units that contains the base. Base bits under the mask have no effect.
- R6: If several windows match, `hit_idx`, `hit_target` and `hit_attr` come from the lowest-numbered matching window.
- R7: If no window matches, `miss` is 1, `hit` is 0, and `hit_idx`, `hit_target` and `hit_attr` are all 0. Exactly one of `hit` and `miss` is 1 at all times.
- R8: `cfg_invalid[i]` is 1 when the size field of window i is not a run of ones from bit 0 followed by zeros. Such a window never matches, even when it is enabled.
- R9: A window whose enable bit is 0 never matches.
- R10: All decode outputs follow `addr` in the same cycle, with no register between `addr` and the outputs.
- R11: With `cfg_we` low, the clock edge leaves every window unchanged. A write whose `cfg_idx` is NUM_WIN or above also changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for one window |
| cfg_idx | input | 3 | Number of the window to write |
| cfg_en | input | 1 | Enable bit to store |
| cfg_base | input | 16 | Base, compared with addr[31:16] |
| cfg_size | input | 16 | Size mask, thermometer code in 64 KB units |
| cfg_target | input | 4 | Target identifier to store |
| cfg_attr | input | 8 | Attribute byte to store |
| addr | input | 32 | Address to decode |
| hit | output | 1 | Some window matched |
| miss | output | 1 | No window matched |
| hit_idx | output | 3 | Number of the winning window |
| hit_target | output | 4 | Target identifier of the winning window |
| hit_attr | output | 8 | Attribute byte of the winning window |
| cfg_invalid | output | 6 | Per-window flag for a malformed size field |

## Verification
The decode outputs are due in the same cycle as the address. The bench therefore changes `addr` and samples one nanosecond later, with no clock edge in between, and no writes happen during a sweep. A configuration write becomes visible at the rising edge on which `cfg_we` is high. The bench drives writes at the falling edge, checks that the decode has not yet changed before the next rising edge, and checks the new decode at the falling edge after it. Each sweep covers all 65536 values of the upper address bits and compares them against a model built from range bounds.

// File: rtl/awd_pkg.sv
package awd_pkg;

  localparam int WSZ_W  = 16;
  localparam int TGT_W  = 4;
  localparam int ATTR_W = 8;

  typedef struct packed {
    logic              en;
    logic [WSZ_W-1:0]  base;
    logic [WSZ_W-1:0]  size;
    logic [TGT_W-1:0]  target;
    logic [ATTR_W-1:0] attr;
  } win_cfg_t;

  // A legal size field is 0...01...1: adding one clears every set bit.
  function automatic logic size_is_thermo(input logic [WSZ_W-1:0] sz);
    logic [WSZ_W:0] plus1;
    plus1 = {1'b0, sz} + {{WSZ_W{1'b0}}, 1'b1};
    return ((plus1[WSZ_W-1:0] & sz) == '0);
  endfunction

  // Masked equality of the upper address bits against a base.
  function automatic logic masked_eq(input logic [WSZ_W-1:0] hi,
                                     input logic [WSZ_W-1:0] base,
                                     input logic [WSZ_W-1:0] sz);
    return (((hi ^ base) & ~sz) == '0);
  endfunction

endpackage

// File: rtl/awd_win_regs.sv
module awd_win_regs
  import awd_pkg::*;
#(
  parameter int NUM_WIN = 6,
  localparam int IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  win_cfg_t                 wr_cfg,
  output win_cfg_t [NUM_WIN-1:0]   cfg_q
);

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[g] <= '0;
      end else if (sel) begin
        cfg_q[g] <= wr_cfg;
      end
    end
  end

endmodule

// File: rtl/awd_win_cmp.sv
module awd_win_cmp
  import awd_pkg::*;
#(
  parameter int NUM_WIN = 6
) (
  input  logic [WSZ_W-1:0]         addr_hi,
  input  win_cfg_t [NUM_WIN-1:0]   cfg_q,
  output logic [NUM_WIN-1:0]       win_hit,
  output logic [NUM_WIN-1:0]       win_bad
);

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
    logic legal;
    logic eq;
    assign legal      = size_is_thermo(cfg_q[g].size);
    assign eq         = masked_eq(addr_hi, cfg_q[g].base, cfg_q[g].size);
    assign win_bad[g] = !legal;
    assign win_hit[g] = cfg_q[g].en && legal && eq;
  end

endmodule

// File: rtl/awd_prio_sel.sv
module awd_prio_sel
  import awd_pkg::*;
#(
  parameter int NUM_WIN = 6,
  localparam int IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic [NUM_WIN-1:0]       win_hit,
  input  win_cfg_t [NUM_WIN-1:0]   cfg_q,
  output logic                     any_hit,
  output logic [IDX_W-1:0]         sel_idx,
  output logic [TGT_W-1:0]         sel_target,
  output logic [ATTR_W-1:0]        sel_attr
);

  always_comb begin
    any_hit    = 1'b0;
    sel_idx    = '0;
    sel_target = '0;
    sel_attr   = '0;
    // Walk from the top so the lowest matching window is the last to write.
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (win_hit[i]) begin
        any_hit    = 1'b1;
        sel_idx    = IDX_W'(i);
        sel_target = cfg_q[i].target;
        sel_attr   = cfg_q[i].attr;
      end
    end
  end

endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
  import awd_pkg::*;
#(
  parameter int NUM_WIN = 6,
  parameter int ADDR_W  = 32,
  localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [IDX_W-1:0]     cfg_idx,
  input  logic                 cfg_en,
  input  logic [WSZ_W-1:0]     cfg_base,
  input  logic [WSZ_W-1:0]     cfg_size,
  input  logic [TGT_W-1:0]     cfg_target,
  input  logic [ATTR_W-1:0]    cfg_attr,
  input  logic [ADDR_W-1:0]    addr,
  output logic                 hit,
  output logic                 miss,
  output logic [IDX_W-1:0]     hit_idx,
  output logic [TGT_W-1:0]     hit_target,
  output logic [ATTR_W-1:0]    hit_attr,
  output logic [NUM_WIN-1:0]   cfg_invalid
);

  win_cfg_t                wr_cfg;
  win_cfg_t [NUM_WIN-1:0]  cfg_q;
  logic [NUM_WIN-1:0]      win_hit;
  logic [NUM_WIN-1:0]      win_en;
  logic [WSZ_W-1:0]        addr_hi;
  logic                    any_hit;

  assign wr_cfg = '{en: cfg_en, base: cfg_base, size: cfg_size,
                    target: cfg_target, attr: cfg_attr};
  assign addr_hi = addr[ADDR_W-1 -: WSZ_W];

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_en
    assign win_en[g] = cfg_q[g].en;
  end

  awd_win_regs #(.NUM_WIN(NUM_WIN)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_we),
    .wr_idx (cfg_idx),
    .wr_cfg (wr_cfg),
    .cfg_q  (cfg_q)
  );

  awd_win_cmp #(.NUM_WIN(NUM_WIN)) u_cmp (
    .addr_hi (addr_hi),
    .cfg_q   (cfg_q),
    .win_hit (win_hit),
    .win_bad (cfg_invalid)
  );

  awd_prio_sel #(.NUM_WIN(NUM_WIN)) u_sel (
    .win_hit    (win_hit),
    .cfg_q      (cfg_q),
    .any_hit    (any_hit),
    .sel_idx    (hit_idx),
    .sel_target (hit_target),
    .sel_attr   (hit_attr)
  );

  assign hit  = any_hit;
  assign miss = (win_hit == '0);

endmodule

// File: rtl/awd_checker.sv
module awd_checker #(
  parameter int NUM_WIN = 6,
  parameter int IDX_W   = 3,
  parameter int TGT_W   = 4,
  parameter int ATTR_W  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_we,
  input logic               hit,
  input logic               miss,
  input logic [IDX_W-1:0]   hit_idx,
  input logic [TGT_W-1:0]   hit_target,
  input logic [ATTR_W-1:0]  hit_attr,
  input logic [NUM_WIN-1:0] cfg_invalid,
  input logic [NUM_WIN-1:0] win_hit,
  input logic [NUM_WIN-1:0] win_en
);

  logic [NUM_WIN-1:0] below;
  logic [NUM_WIN-1:0] won_bit;
  assign won_bit = NUM_WIN'(1) << hit_idx;
  assign below   = won_bit - NUM_WIN'(1);

  // R7
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> (hit_idx == '0 && hit_target == '0 && hit_attr == '0));

  // R7
  hit_xor_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({hit, miss}));

  // R6
  lowest_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((win_hit & won_bit) != '0 && (win_hit & below) == '0));

  // R9
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_hit & ~win_en) == '0);

  // R8
  invalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_hit & cfg_invalid) == '0);

  // R11
  hold_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(cfg_invalid) && $stable(win_en)));

endmodule

bind addr_window_decoder awd_checker #(
  .NUM_WIN (NUM_WIN),
  .IDX_W   (IDX_W),
  .TGT_W   (awd_pkg::TGT_W),
  .ATTR_W  (awd_pkg::ATTR_W)
) u_awd_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_we      (cfg_we),
  .hit         (hit),
  .miss        (miss),
  .hit_idx     (hit_idx),
  .hit_target  (hit_target),
  .hit_attr    (hit_attr),
  .cfg_invalid (cfg_invalid),
  .win_hit     (win_hit),
  .win_en      (win_en)
);

// File: tb/addr_window_decoder_test.sv
`timescale 1ns/1ps
module addr_window_decoder_test;

  localparam int NW = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_idx;
  logic        cfg_en;
  logic [15:0] cfg_base;
  logic [15:0] cfg_size;
  logic [3:0]  cfg_target;
  logic [7:0]  cfg_attr;
  logic [31:0] addr;
  logic        hit, miss;
  logic [2:0]  hit_idx;
  logic [3:0]  hit_target;
  logic [7:0]  hit_attr;
  logic [5:0]  cfg_invalid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int m_en   [NW];
  int m_base [NW];
  int m_size [NW];
  int m_tgt  [NW];
  int m_attr [NW];

  always #5 clk = ~clk;

  addr_window_decoder uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_en(cfg_en), .cfg_base(cfg_base), .cfg_size(cfg_size),
    .cfg_target(cfg_target), .cfg_attr(cfg_attr), .addr(addr),
    .hit(hit), .miss(miss), .hit_idx(hit_idx), .hit_target(hit_target),
    .hit_attr(hit_attr), .cfg_invalid(cfg_invalid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Range model: k ones -> 2^k units starting at base rounded down.
  function automatic bit size_legal(input int sz);
    int k = $countones(sz[15:0]);
    return (sz == ((1 << k) - 1));
  endfunction

  function automatic int model_idx(input int a);
    for (int i = 0; i < NW; i++) begin
      int k;
      int lo;
      k = $countones(m_size[i][15:0]);
      lo = (m_base[i] >> k) << k;
      if (m_en[i] != 0 && size_legal(m_size[i]) && a >= lo && a < lo + (1 << k))
        return i;
    end
    return -1;
  endfunction

  function automatic int model_bad();
    int v = 0;
    for (int i = 0; i < NW; i++) if (!size_legal(m_size[i])) v |= (1 << i);
    return v;
  endfunction

  task automatic wr(input int idx, input int en, input int base, input int sz,
                    input int tgt, input int at);
    @(negedge clk);
    cfg_idx = idx[2:0]; cfg_en = en[0]; cfg_base = base[15:0];
    cfg_size = sz[15:0]; cfg_target = tgt[3:0]; cfg_attr = at[7:0];
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    if (idx < NW) begin
      m_en[idx] = en; m_base[idx] = base; m_size[idx] = sz;
      m_tgt[idx] = tgt; m_attr[idx] = at;
    end
  endtask

  task automatic probe(input int a, input string req);
    int e;
    addr = {a[15:0], 16'((a * 37) ^ 16'hA5C3)};
    #1;
    e = model_idx(a);
    if (e < 0) begin
      check(miss && !hit && hit_idx == 0 && hit_target == 0 && hit_attr == 0,
            req, {hit, miss, hit_idx}, 1);
    end else begin
      check(hit && !miss && hit_idx == e[2:0] && hit_target == m_tgt[e][3:0]
            && hit_attr == m_attr[e][7:0], req, {hit_idx, hit_target, hit_attr},
            {e[2:0], m_tgt[e][3:0], m_attr[e][7:0]});
    end
  endtask

  task automatic sweep(input string req);
    for (int a = 0; a < 65536; a++) probe(a, req);
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_en = 1'b0; cfg_base = '0;
    cfg_size = '0; cfg_target = '0; cfg_attr = '0; addr = '0;
    for (int i = 0; i < NW; i++) begin
      m_en[i] = 0; m_base[i] = 0; m_size[i] = 0; m_tgt[i] = 0; m_attr[i] = 0;
    end
    #2;
    // R1: reset state while reset is held
    check(miss && !hit && cfg_invalid == 0, "R1", {hit, miss, cfg_invalid}, 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(miss && !hit && cfg_invalid == 0, "R1", {hit, miss, cfg_invalid}, 1);

    // R2: write takes effect at the rising edge, not before
    addr = 32'h8123_4567;
    @(negedge clk);
    cfg_idx = 3'd2; cfg_en = 1'b1; cfg_base = 16'h8000; cfg_size = 16'h07FF;
    cfg_target = 4'd3; cfg_attr = 8'hA2; cfg_we = 1'b1;
    #1;
    check(miss, "R2", hit, 0);
    @(negedge clk);
    cfg_we = 1'b0;
    m_en[2] = 1; m_base[2] = 16'h8000; m_size[2] = 16'h07FF; m_tgt[2] = 3; m_attr[2] = 8'hA2;
    check(hit && hit_idx == 2 && hit_target == 3, "R2", hit_idx, 2);

    // Window set: nested (R6), small (R4), masked base bits (R5), invalid (R8), disabled (R9)
    wr(0, 1, 16'hE050, 16'h0000, 1, 8'hA0);
    wr(1, 1, 16'hE123, 16'h0FFF, 2, 8'hA1);
    wr(3, 1, 16'h8800, 16'h07FF, 4, 8'hA3);
    wr(4, 1, 16'h4000, 16'h0F0F, 5, 8'hA4);
    wr(5, 0, 16'h2000, 16'h00FF, 6, 8'hA5);
    check(cfg_invalid == model_bad(), "R8", cfg_invalid, model_bad());

    probe(16'hE050, "R4");
    probe(16'hE051, "R4");
    probe(16'hE04F, "R6");
    probe(16'hEFFF, "R5");
    probe(16'hF000, "R5");
    probe(16'h4000, "R8");
    probe(16'h2010, "R9");

    // R10: output follows address with no clock edge in between
    @(negedge clk);
    addr = 32'hE050_0000; #1;
    check(hit && hit_idx == 0, "R10", hit_idx, 0);
    addr = 32'h8000_FFFF; #1;
    check(hit && hit_idx == 2, "R10", hit_idx, 2);
    addr = 32'h0000_0000; #1;
    check(miss, "R10", hit, 0);

    sweep("R3");

    // R11: edges without a strobe, and an out-of-range index, change nothing
    @(negedge clk);
    cfg_idx = 3'd2; cfg_en = 1'b0; cfg_base = 16'h1111; cfg_size = 16'h0001;
    cfg_target = 4'hF; cfg_attr = 8'hFF;
    repeat (3) @(negedge clk);
    probe(16'h8000, "R11");
    wr(6, 1, 16'h0000, 16'hFFFF, 7, 8'h77);
    wr(7, 1, 16'h0000, 16'hFFFF, 7, 8'h77);
    probe(16'h0100, "R11");
    check(cfg_invalid == model_bad(), "R11", cfg_invalid, model_bad());

    // R9: enabling window 5 brings it into the decode
    wr(5, 1, 16'h20AB, 16'h00FF, 6, 8'hA5);
    sweep("R9");

    // R8/R5: repaired window 4 covering the whole space catches everything else
    wr(4, 1, 16'h1234, 16'hFFFF, 5, 8'hA4);
    check(cfg_invalid == 0, "R8", cfg_invalid, 0);
    sweep("R6");

    // R1: reset again clears the windows
    rst_n = 1'b0; #1;
    check(miss && cfg_invalid == 0, "R1", {hit, cfg_invalid}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule